// File: doc/BRIEF.md
# Parallel ADC Read Sequencer

This block sits on the host side of a parallel-output successive-approximation converter and runs it in a loop. Each conversion is started either by a one-cycle request pulse or by an internal period counter. The sequencer drives the converter's active-low convert-start, chip-select and read strobes and its byte-select line. It then waits for the converter's busy flag to rise and fall, reads the result and presents it as a single-cycle valid strobe with a data word.

The sequencer has two capture modes. In word mode it reads the whole bus once. In byte mode it reads twice from the upper half of the bus. The first read is taken with byte select low and returns the most significant byte. Byte select is then raised, and the second read returns the least significant byte folded onto those same upper pins. Every interface interval is a parameterised count of clock cycles. These intervals are:
- chip-select setup;
- the bus-quiet window before the sampling edge;
- the convert pulse width;
- the data delay after busy falls;
- read width and read gap;
- byte setup and byte-edge spacing.

Top module: `adc_rd_seq`

## Requirements
- R1: During and after reset, conv_n, cs_n and rd_n are high, byte_sel is low, and smp_valid and overrun are low.
- R2: A request accepted while idle first drives cs_n low. conv_n falls only while cs_n is low and no sooner than CS_SU_CYC cycles after cs_n fell.
- R3: conv_n stays low for exactly CONV_LO_CYC clock cycles per conversion.
- R4: rd_n never falls while busy is high. The first fall of rd_n comes at least DATA_DLY_CYC cycles after busy has fallen in the current conversion.
- R5: Word mode (byte_mode = 0) performs one read with byte_sel held low. smp_data equals the full bus value.
- R6: Byte mode (byte_mode = 1) performs two reads of bus bits [DW-1:DW/2].
  - The first read has byte_sel = 0 and supplies result bits [DW-1:DW/2]. The second read has byte_sel = 1 and supplies result bits [DW/2-1:0].
  - byte_sel is stable while rd_n is low and for at least BYTE_SU_CYC cycles before rd_n falls.
  - Consecutive byte_sel edges are at least BYTE_SP_CYC cycles apart.
- R7: No edge of rd_n, cs_n or byte_sel occurs within QUIET_CYC cycles before a falling edge of conv_n.
- R8: smp_valid is a one-cycle pulse. It rises on the same edge on which cs_n returns high at the end of the sequence.
- R9: With auto_en high and the sequence shorter than the period, conv_n falls exactly every period_cyc cycles.
- R10: A request, either a start_req pulse or a period tick, that arrives while a sequence is in progress is dropped. It raises overrun for one cycle and starts no extra conversion.
- R11: byte_mode is sampled when a request is accepted. Changing it during a sequence does not change the number of reads in that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-shot conversion request |
| auto_en | input | 1 | Enables periodic conversions |
| period_cyc | input | PW | Sample period in clock cycles |
| byte_mode | input | 1 | 1 = two 8-bit reads on upper byte, 0 = one full-width read |
| busy | input | 1 | Converter busy flag (asynchronous) |
| db | input | DW | Converter parallel data bus |
| conv_n | output | 1 | Convert start, active low |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| byte_sel | output | 1 | Byte select (fold low byte onto upper pins) |
| smp_valid | output | 1 | One-cycle result strobe |
| smp_data | output | DW | Assembled result |
| overrun | output | 1 | One-cycle pulse when a request is dropped |

## Verification
Two situations are hard to reach from the ports. The first is a request landing in the middle of a sequence. The second is a byte_mode change after the request has been accepted but before the reads. A plain request stream never produces either one. The bench therefore pulses start_req and flips byte_mode at fixed offsets after cs_n falls, then counts reads and conversions up to the next result. The converter model returns words with all-ones or all-zeros halves. With those words, a read of the wrong pins or a swapped byte order shows up directly in smp_data.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [3:0] {
      S_IDLE,
      S_SETUP,
      S_CONV,
      S_WBUSY,
      S_DLY,
      S_RD1,
      S_GAP,
      S_RD2,
      S_FIN
   } seq_state_t;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else if (STAGES == 1) sh <= din;
            else sh <= {sh[STAGES-2:0], din};
         end
         assign dout = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/adc_pacer.sv
module adc_pacer #(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [PW-1:0] period,
   output logic          tick
);
   logic [PW-1:0] cnt;
   logic [PW:0]   nxt;

   assign nxt  = {1'b0, cnt} + (PW+1)'(1);
   assign tick = en && (nxt >= {1'b0, period});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!en)  cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= nxt[PW-1:0];
   end

   // R9: a tick never repeats on back-to-back cycles unless the period is one or zero
   a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en && period > PW'(1)) |=> !tick);
endmodule

// File: rtl/adc_bus_quiet.sv
module adc_bus_quiet #(
   parameter int LIMIT = 16,
   localparam int QW = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          byte_sel,
   output logic [QW-1:0] calm_cnt,
   output logic          calm_ok
);
   localparam logic [QW-1:0] TOP = QW'(LIMIT);

   logic p_cs, p_rd, p_byte;
   logic edge_now;

   assign edge_now = (cs_n != p_cs) || (rd_n != p_rd) || (byte_sel != p_byte);
   assign calm_ok  = (calm_cnt == TOP) && !edge_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_cs     <= 1'b1;
         p_rd     <= 1'b1;
         p_byte   <= 1'b0;
         calm_cnt <= TOP;
      end else begin
         p_cs   <= cs_n;
         p_rd   <= rd_n;
         p_byte <= byte_sel;
         if (edge_now)            calm_cnt <= '0;
         else if (calm_cnt != TOP) calm_cnt <= calm_cnt + QW'(1);
      end
   end

   // R7: the calm counter restarts after any bus edge
   a_r7_calm_restart: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(rd_n) || $changed(cs_n) || $changed(byte_sel)) |=> (calm_cnt == '0));
endmodule

// File: rtl/adc_word_asm.sv
module adc_word_asm #(
   parameter int DW = 16,
   localparam int HW = DW / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          full,
   input  logic          cap_first,
   input  logic          cap_second,
   input  logic          publish,
   input  logic [DW-1:0] bus,
   output logic          valid,
   output logic [DW-1:0] data
);
   logic [DW-1:0] word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         data  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= publish;
         if (cap_first) begin
            if (full) word <= bus;
            else      word[DW-1:HW] <= bus[DW-1:HW];
         end
         if (cap_second) word[HW-1:0] <= bus[DW-1:HW];
         if (publish)    data <= word;
      end
   end

   // R8: the result strobe lasts one cycle
   a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
   import adc_seq_pkg::*;
#(
   parameter int DW           = 16,
   parameter int PW           = 16,
   parameter int CS_SU_CYC    = 3,
   parameter int QUIET_CYC    = 16,
   parameter int CONV_LO_CYC  = 6,
   parameter int CONV_LO_MAX  = 49,
   parameter int DATA_DLY_CYC = 5,
   parameter int RD_LO_CYC    = 4,
   parameter int RD_HI_CYC    = 4,
   parameter int BYTE_SU_CYC  = 2,
   parameter int BYTE_SP_CYC  = 7,
   parameter int BUSY_SYNC    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_req,
   input  logic          auto_en,
   input  logic [PW-1:0] period_cyc,
   input  logic          byte_mode,
   input  logic          busy,
   input  logic [DW-1:0] db,
   output logic          conv_n,
   output logic          cs_n,
   output logic          rd_n,
   output logic          byte_sel,
   output logic          smp_valid,
   output logic [DW-1:0] smp_data,
   output logic          overrun
);
   localparam int LEAD_CYC = (CS_SU_CYC > QUIET_CYC) ? CS_SU_CYC : QUIET_CYC;
   localparam int SPAN = LEAD_CYC + CONV_LO_MAX + DATA_DLY_CYC + RD_LO_CYC
                       + RD_HI_CYC + BYTE_SU_CYC + BYTE_SP_CYC;
   localparam int CW = $clog2(SPAN + 1);
   localparam int QW = $clog2(LEAD_CYC + 1);

   localparam logic [CW-1:0] K_CONV = CW'(CONV_LO_CYC - 1);
   localparam logic [CW-1:0] K_DLY  = CW'(DATA_DLY_CYC - 1);
   localparam logic [CW-1:0] K_RDLO = CW'(RD_LO_CYC - 1);
   localparam logic [CW-1:0] K_BYUP = CW'(RD_HI_CYC - 1);
   localparam logic [CW-1:0] K_RD2  = CW'(RD_HI_CYC + BYTE_SU_CYC - 1);
   localparam logic [CW-1:0] K_FIN  = CW'(BYTE_SP_CYC - 1);

   generate
      if (DW < 2 || (DW % 2) != 0) begin : g_bad_dw
         $error("DW must be even and at least 2");
      end
      if (CONV_LO_CYC < 1 || CONV_LO_CYC > CONV_LO_MAX) begin : g_bad_conv
         $error("CONV_LO_CYC out of range");
      end
      if (DATA_DLY_CYC < 1 || RD_LO_CYC < 1 || RD_HI_CYC < 1 ||
          BYTE_SU_CYC < 1 || BYTE_SP_CYC < 1 || CS_SU_CYC < 1) begin : g_bad_tim
         $error("timing counts must be at least one");
      end
      if (BUSY_SYNC < 0 || BUSY_SYNC > 3) begin : g_bad_sync
         $error("BUSY_SYNC must be 0..3");
      end
   endgenerate

   seq_state_t    state;
   logic [CW-1:0] cnt;
   logic          seen_q;
   logic          mode_q;
   logic          tick, trig;
   logic          busy_s;
   logic          calm_ok;
   logic [QW-1:0] calm_cnt;
   logic          cap_first, cap_second, publish;

   adc_sync #(.STAGES(BUSY_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(busy), .dout(busy_s)
   );

   adc_pacer #(.PW(PW)) u_pace (
      .clk(clk), .rst_n(rst_n), .en(auto_en), .period(period_cyc), .tick(tick)
   );

   adc_bus_quiet #(.LIMIT(LEAD_CYC)) u_quiet (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .byte_sel(byte_sel),
      .calm_cnt(calm_cnt), .calm_ok(calm_ok)
   );

   adc_word_asm #(.DW(DW)) u_asm (
      .clk(clk), .rst_n(rst_n), .full(!mode_q), .cap_first(cap_first),
      .cap_second(cap_second), .publish(publish), .bus(db),
      .valid(smp_valid), .data(smp_data)
   );

   assign trig = start_req || tick;

   always_comb begin
      cap_first  = (state == S_RD1) && (cnt == K_RDLO);
      cap_second = (state == S_RD2) && (cnt == K_RDLO);
      publish    = (state == S_FIN) && (cnt == K_FIN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         cnt      <= '0;
         seen_q   <= 1'b0;
         mode_q   <= 1'b0;
         conv_n   <= 1'b1;
         cs_n     <= 1'b1;
         rd_n     <= 1'b1;
         byte_sel <= 1'b0;
         overrun  <= 1'b0;
      end else begin
         overrun <= trig && (state != S_IDLE);
         unique case (state)
            S_IDLE: begin
               if (trig) begin
                  cs_n   <= 1'b0;
                  mode_q <= byte_mode;
                  state  <= S_SETUP;
               end
            end
            S_SETUP: begin
               if (calm_ok) begin
                  conv_n <= 1'b0;
                  cnt    <= '0;
                  seen_q <= 1'b0;
                  state  <= S_CONV;
               end
            end
            S_CONV: begin
               seen_q <= seen_q | busy_s;
               if (cnt == K_CONV) begin
                  conv_n <= 1'b1;
                  cnt    <= '0;
                  state  <= S_WBUSY;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            S_WBUSY: begin
               seen_q <= seen_q | busy_s;
               if (seen_q && !busy_s) begin
                  cnt   <= '0;
                  state <= S_DLY;
               end
            end
            S_DLY: begin
               if (cnt == K_DLY) begin
                  rd_n  <= 1'b0;
                  cnt   <= '0;
                  state <= S_RD1;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            S_RD1: begin
               if (cnt == K_RDLO) begin
                  rd_n  <= 1'b1;
                  cnt   <= '0;
                  state <= mode_q ? S_GAP : S_FIN;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            S_GAP: begin
               if (cnt == K_BYUP) byte_sel <= 1'b1;
               if (cnt == K_RD2) begin
                  rd_n  <= 1'b0;
                  cnt   <= '0;
                  state <= S_RD2;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            S_RD2: begin
               if (cnt == K_RDLO) begin
                  rd_n  <= 1'b1;
                  cnt   <= '0;
                  state <= S_FIN;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            S_FIN: begin
               if (cnt == K_FIN) begin
                  cs_n     <= 1'b1;
                  byte_sel <= 1'b0;
                  cnt      <= '0;
                  state    <= S_IDLE;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R2: conversion starts only with chip select already low
   a_r2_cs_leads_conv: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_n) |-> (!cs_n && $past(!cs_n)));

   // R7: sampling edge follows a full quiet window
   a_r7_quiet_before_conv: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_n) |-> (calm_cnt >= QW'(QUIET_CYC)));

   // R4: no read while the converter reports busy
   a_r4_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> (!busy_s && !cs_n));

   // R5: word-mode sequences keep byte select low
   a_r5_word_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && !cs_n) |-> !byte_sel);

   // R6: byte select does not move during a read
   a_r6_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && $past(!rd_n)) |-> $stable(byte_sel));

   // R8: the result appears as chip select is released
   a_r8_valid_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> (cs_n && $past(!cs_n)));

   // R10: a dropped request only happens during a sequence
   a_r10_overrun_busy: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(!cs_n));
endmodule

// File: tb/sim_adc_rd_seq.sv
module sim_adc_rd_seq;
   localparam int DW = 16;
   localparam int PW = 16;
   localparam int CS_SU = 3;
   localparam int QUIET = 16;
   localparam int CONV_LO = 6;
   localparam int DATA_DLY = 5;
   localparam int BYTE_SU = 2;
   localparam int BYTE_SP = 7;
   localparam int BUSY_LEN = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_req = 1'b0;
   logic auto_en = 1'b0;
   logic [PW-1:0] period_cyc = '0;
   logic byte_mode = 1'b0;
   logic busy;
   logic [DW-1:0] db;
   logic conv_n, cs_n, rd_n, byte_sel, smp_valid, overrun;
   logic [DW-1:0] smp_data;

   always #4 clk = ~clk;

   adc_rd_seq #(.DW(DW), .PW(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .auto_en(auto_en),
      .period_cyc(period_cyc), .byte_mode(byte_mode), .busy(busy), .db(db),
      .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n), .byte_sel(byte_sel),
      .smp_valid(smp_valid), .smp_data(smp_data), .overrun(overrun)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // converter model
   logic          conv_q;
   int            bcnt;
   logic [DW-1:0] cur_word;
   logic [DW-1:0] force_word = '0;
   bit            force_en = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_q   <= 1'b1;
         busy     <= 1'b0;
         bcnt     <= 0;
         cur_word <= '0;
      end else begin
         conv_q <= conv_n;
         if (conv_q && !conv_n) begin
            busy <= 1'b1;
            bcnt <= BUSY_LEN;
         end else if (bcnt > 0) begin
            bcnt <= bcnt - 1;
            if (bcnt == 1) begin
               busy     <= 1'b0;
               cur_word <= force_en ? force_word : DW'($urandom);
            end
         end
      end
   end

   assign db = (!cs_n && !rd_n) ? (byte_sel ? {cur_word[7:0], 8'hFF} : cur_word)
                                : 16'hA5A5;

   // reference: the result word equals the converted word in both modes
   function automatic logic [DW-1:0] exp_result(input logic [DW-1:0] w);
      return w;
   endfunction

   // monitor
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   bit  mon_en = 0;
   bit  pace_on = 0;
   bit  have_prev = 0;
   int  last_bus = -1000, last_cs_fall = -1000, last_byte = -1000;
   int  conv_fall = 0, busy_fall = 0, prev_conv = 0;
   bit  seen_bf = 0, exp_mode = 0;
   int  rd_cnt = 0, byte_cnt = 0, n_conv = 0, n_ovr = 0, n_valid = 0;
   logic p_conv = 1, p_cs = 1, p_rd = 1, p_byte = 0, p_busy = 0, p_valid = 0;

   always @(negedge clk) begin
      if (rst_n && mon_en) begin
         if (!pace_on) have_prev = 0;
         if (p_cs && !cs_n) begin
            last_cs_fall = cyc;
            exp_mode = byte_mode;
         end
         if (p_conv && !conv_n) begin
            chk(!cs_n, "R2 cs low at conv", cs_n, 0);
            chk(cyc - last_cs_fall >= CS_SU, "R2 cs setup", cyc - last_cs_fall, CS_SU);
            chk(cyc - last_bus >= QUIET, "R7 quiet window", cyc - last_bus, QUIET);
            if (pace_on && have_prev)
               chk(cyc - prev_conv == int'(period_cyc), "R9 period",
                   cyc - prev_conv, period_cyc);
            if (pace_on) have_prev = 1;
            prev_conv = cyc;
            conv_fall = cyc;
            seen_bf = 0;
            rd_cnt = 0;
            byte_cnt = 0;
            n_conv++;
         end
         if (!p_conv && conv_n)
            chk(cyc - conv_fall == CONV_LO, "R3 conv width", cyc - conv_fall, CONV_LO);
         if (p_busy && !busy) begin
            busy_fall = cyc;
            seen_bf = 1;
         end
         if (p_rd && !rd_n) begin
            chk(seen_bf && !busy && (cyc - busy_fall >= DATA_DLY), "R4 read after busy",
                cyc - busy_fall, DATA_DLY);
            chk(cyc - last_byte >= BYTE_SU, "R6 byte setup", cyc - last_byte, BYTE_SU);
            rd_cnt++;
         end
         if (p_byte != byte_sel) begin
            chk(rd_n && p_rd, "R6 byte stable in read", rd_n, 1);
            chk(cyc - last_byte >= BYTE_SP, "R6 byte spacing", cyc - last_byte, BYTE_SP);
            last_byte = cyc;
            byte_cnt++;
         end
         if (p_cs != cs_n || p_rd != rd_n || p_byte != byte_sel) last_bus = cyc;
         if (overrun) n_ovr++;
         if (smp_valid) begin
            n_valid++;
            chk(!p_valid, "R8 valid one cycle", p_valid, 0);
            chk(cs_n && !p_cs, "R8 valid with cs release", cs_n, 1);
            chk(rd_cnt == (exp_mode ? 2 : 1), "R11 read count", rd_cnt, exp_mode ? 2 : 1);
            if (exp_mode) begin
               chk(smp_data == exp_result(cur_word), "R6 byte result", smp_data,
                   exp_result(cur_word));
            end else begin
               chk(smp_data == exp_result(cur_word), "R5 word result", smp_data,
                   exp_result(cur_word));
               chk(byte_cnt == 0, "R5 byte held low", byte_cnt, 0);
            end
         end
      end
      p_conv = conv_n; p_cs = cs_n; p_rd = rd_n; p_byte = byte_sel;
      p_busy = busy; p_valid = smp_valid;
   end

   task automatic wait_valid(input string tag);
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         if (smp_valid) return;
      end
      chk(0, tag, 0, 1);
   endtask

   task automatic run_one(input bit mode, input bit fe, input logic [DW-1:0] w,
                          input int gap);
      @(negedge clk);
      byte_mode = mode;
      force_en = fe;
      force_word = w;
      start_req = 1;
      @(negedge clk);
      start_req = 0;
      wait_valid("R2 sequence completes");
      repeat (gap) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      chk(conv_n && cs_n && rd_n && !byte_sel, "R1 strobes in reset",
          {conv_n, cs_n, rd_n, byte_sel}, 4'b1110);
      rst_n = 1;
      repeat (3) @(negedge clk);
      chk(conv_n && cs_n && rd_n && !byte_sel && !smp_valid && !overrun,
          "R1 idle after reset", {conv_n, cs_n, rd_n, byte_sel, smp_valid, overrun},
          6'b111000);
      mon_en = 1;

      // directed fold corners
      run_one(1, 1, 16'h0000, 3);
      run_one(1, 1, 16'hFFFF, 0);
      run_one(1, 1, 16'h00FF, 2);
      run_one(1, 1, 16'hFF00, 0);
      run_one(1, 1, 16'h8001, 1);
      run_one(0, 1, 16'hFFFF, 0);
      run_one(0, 1, 16'h1234, 0);

      // R11: mode flips after acceptance
      @(negedge clk);
      byte_mode = 0; force_en = 0; start_req = 1;
      @(negedge clk); start_req = 0;
      repeat (8) @(negedge clk); byte_mode = 1;
      wait_valid("R11 sequence completes");
      @(negedge clk);
      byte_mode = 1; start_req = 1;
      @(negedge clk); start_req = 0;
      repeat (8) @(negedge clk); byte_mode = 0;
      wait_valid("R11 sequence completes");

      // R10: request in the middle of a sequence
      begin
         int c0, o0;
         repeat (5) @(negedge clk);
         c0 = n_conv; o0 = n_ovr;
         start_req = 1;
         @(negedge clk); start_req = 0;
         repeat (20) @(negedge clk);
         start_req = 1;
         @(negedge clk); start_req = 0;
         wait_valid("R10 sequence completes");
         repeat (60) @(negedge clk);
         chk(n_ovr == o0 + 1, "R10 overrun pulse count", n_ovr - o0, 1);
         chk(n_conv == c0 + 1, "R10 no extra conversion", n_conv - c0, 1);
         chk(cs_n, "R10 idle afterwards", cs_n, 1);
      end

      // R9: periodic pacing
      begin
         int c0;
         period_cyc = 16'd100;
         byte_mode = 1;
         pace_on = 1;
         c0 = n_conv;
         auto_en = 1;
         while (n_conv < c0 + 5) @(negedge clk);
         auto_en = 0;
         pace_on = 0;
         repeat (120) @(negedge clk);
         chk(cs_n && n_conv == c0 + 5, "R9 pacing stops", n_conv - c0, 5);
      end

      // constrained random
      for (int k = 0; k < 40; k++)
         run_one(1'($urandom % 2), 0, '0, int'($urandom % 21));

      chk(n_valid >= 50, "R8 result count", n_valid, 50);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R2 actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule